// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two WIDTH-bit numbers one bit per clock. It uses a single one-bit full-adder slice and a one-bit carry flop. The accumulator holds the first operand and the operand register holds the second. Both shift right, so the least-significant bits reach the slice first. Each sum bit enters the top of the accumulator, and after WIDTH steps the accumulator holds the sum in place of its old contents. While the operand register shifts out its old value, it takes in a new operand from the serial line at its top end.

A small sequencer starts a pass on a one-cycle start pulse. It counts exactly WIDTH gated shift steps and then pulses done for one cycle. A step happens only on a cycle where the pass is active and shift control is high. Every other cycle keeps all state as it is.

A typical sequence loads the first operand with one pass and copies it into a cleared accumulator with a second pass, which also loads the second operand. A third pass then forms the sum. The carry is cleared at the start of every pass, and the carry out of the top bit is discarded.

Top module: `serial_add_unit`

## Requirements
- R1: After reset, the accumulator, the operand register, busy and done are all 0.
- R2: Each step writes x XOR y XOR carry into the accumulator MSB and shifts the accumulator right. Here x is the accumulator LSB and y is the operand-register LSB. After a complete pass the accumulator equals (old accumulator + old operand) mod 2^WIDTH.
- R3: The carry flop is set on a step where x and y are both 1, cleared on a step where both are 0, and held otherwise. It is cleared when a pass is accepted, so the carry out of one pass never enters the next.
- R4: On each step the operand register shifts right and takes ser_in into its MSB. After a pass, the bit presented on the first step sits in bit 0 and the bit presented on the last step sits in bit WIDTH-1.
- R5: Within a pass, a cycle with shift_en low leaves the accumulator, the operand register and the carry unchanged.
- R6: busy goes high the cycle after an accepted start. A pass performs exactly WIDTH steps. On the cycle after the last step, done is high for one cycle and busy is low.
- R7: A start pulse while busy is ignored: the pass length and its result do not change.
- R8: A synchronous clr zeroes the accumulator and the carry and leaves the operand register unchanged.
- R9: shift_en has no effect while no pass is active.
- R10: With the accumulator cleared, one pass copies the operand register into the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of accumulator and carry |
| start | input | 1 | One-cycle pulse that begins a pass when idle |
| shift_en | input | 1 | Gates each shift step during a pass |
| ser_in | input | 1 | Serial data entering the operand register |
| acc_q | output | WIDTH | Accumulator contents |
| opb_q | output | WIDTH | Operand register contents |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse after the final step of a pass |

## Verification
On every cycle, the in-line properties check the following local rules: the JK-style set, clear and hold of the carry, the hold of both shift registers on cycles without a step, the bit entering each register's top end, and the single-cycle shape of done. Only the bench scenarios show the end-to-end results. These are the full WIDTH-bit sum, the LSB-first placement of the incoming operand, the copy pass into a cleared accumulator, and the fact that a step count of exactly WIDTH is unaffected by stray start pulses and gaps. The bench also shows that a carry out of one pass does not leak into the next.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Outputs of the one-bit adder slice: sum bit and JK-style carry terms.
    typedef struct packed {
        logic sum;
        logic set_c;
        logic clr_c;
    } slice_t;

    function automatic slice_t add_slice(input logic x, input logic y, input logic c);
        slice_t s;
        s.sum   = x ^ y ^ c;
        s.set_c = x & y;
        s.clr_c = ~x & ~y;
        return s;
    endfunction

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             sin,
    output logic [WIDTH-1:0] q,
    output logic             sout
);

    logic [WIDTH-1:0] nxt;

    // One right-shift cell per bit; the top cell takes the serial input.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        if (i == WIDTH - 1) begin : g_top
            assign nxt[i] = sin;
        end else begin : g_mid
            assign nxt[i] = q[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (shift) begin
            q <= nxt;
        end
    end

    assign sout = q[0];

    // R5: no step, no clear -> contents hold
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(q));

    // R4 (and R2 for the accumulator): the serial input lands in the MSB
    assert_msb_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (shift && !clr) |=> (q[WIDTH-1] == $past(sin)));

    // R8: clear empties the register
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (q == '0));

endmodule

// File: rtl/sadd_carry.sv
module sadd_carry
    import sadd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic x,
    input  logic y,
    output logic c
);

    slice_t terms;
    assign terms = add_slice(x, y, c);

    always_ff @(posedge clk) begin
        if (rst) begin
            c <= 1'b0;
        end else if (clr) begin
            c <= 1'b0;
        end else if (en) begin
            if (terms.set_c) begin
                c <= 1'b1;
            end else if (terms.clr_c) begin
                c <= 1'b0;
            end
        end
    end

    assert_carry_set_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && x && y) |=> c);

    assert_carry_kill_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && !x && !y) |=> !c);

    assert_carry_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && (x != y)) |=> $stable(c));

    assert_carry_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(c));

    assert_carry_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> !c);

endmodule

// File: rtl/sadd_seq.sv
module sadd_seq
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic shift_en,
    output logic launch,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    seq_state_e      state;
    logic [CW-1:0]   cnt;

    assign busy   = (state == SEQ_RUN);
    assign launch = (state == SEQ_IDLE) && start;
    assign step   = busy && shift_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_RUN;
                        cnt   <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (shift_en) begin
                        if (cnt == LAST) begin
                            state <= SEQ_IDLE;
                            done  <= 1'b1;
                        end
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_after_step_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(step));

    assert_busy_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_no_step_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !step);

endmodule

// File: rtl/serial_add_unit.sv
module serial_add_unit
    import sadd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [WIDTH-1:0] acc_q,
    output logic [WIDTH-1:0] opb_q,
    output logic             busy,
    output logic             done
);

    logic   launch;
    logic   step;
    logic   x_bit;
    logic   y_bit;
    logic   carry;
    slice_t slice;

    sadd_seq #(.WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .shift_en (shift_en),
        .launch   (launch),
        .step     (step),
        .busy     (busy),
        .done     (done)
    );

    assign slice = add_slice(x_bit, y_bit, carry);

    sadd_shreg #(.WIDTH(WIDTH)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .shift (step),
        .sin   (slice.sum),
        .q     (acc_q),
        .sout  (x_bit)
    );

    sadd_shreg #(.WIDTH(WIDTH)) u_opb (
        .clk   (clk),
        .rst   (rst),
        .clr   (1'b0),
        .shift (step),
        .sin   (ser_in),
        .q     (opb_q),
        .sout  (y_bit)
    );

    sadd_carry u_carry (
        .clk (clk),
        .rst (rst),
        .clr (clr | launch),
        .en  (step),
        .x   (x_bit),
        .y   (y_bit),
        .c   (carry)
    );

    // R3: an accepted start leaves the carry empty for the first step
    assert_carry_fresh_R3: assert property (@(posedge clk) disable iff (rst)
        launch |=> !carry);

    // R8: clr does not disturb the operand register
    assert_clr_keeps_b_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !step) |=> $stable(opb_q));

endmodule

// File: tb/test_serial_add_unit.sv
module test_serial_add_unit;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst, clr, start, shift_en, ser_in;
    logic [W-1:0] acc_q, opb_q;
    logic         busy, done;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [W-1:0] acc;
        logic [W-1:0] opb;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] m_a, m_b;

    always #4 clk = ~clk;

    serial_add_unit #(.WIDTH(W)) i_serial_add_unit (
        .clk(clk), .rst(rst), .clr(clr), .start(start), .shift_en(shift_en),
        .ser_in(ser_in), .acc_q(acc_q), .opb_q(opb_q), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: on each done pulse pop the next expected result
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk("R6 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R2 sum", 32'(acc_q), 32'(e.acc));
                chk("R4 operand", 32'(opb_q), 32'(e.opb));
            end
        end
    end

    // Driver: one pass; gap_every>0 inserts idle cycles, poke issues a stray start
    task automatic run_pass(input logic [W-1:0] opd, input int gap_every, input bit poke);
        exp_t e;
        e.acc = m_a + m_b;
        e.opb = opd;
        sb.push_back(e);
        m_a = e.acc;
        m_b = opd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 busy after start", 32'(busy), 32'd1);
        for (int i = 0; i < W; i++) begin
            if (gap_every > 0 && (i % gap_every) == 1) begin
                logic [W-1:0] sa, sbv;
                sa = acc_q;
                sbv = opb_q;
                shift_en = 1'b0;
                ser_in = ~opd[i];
                @(negedge clk);
                chk("R5 gap keeps acc", 32'(acc_q), 32'(sa));
                chk("R5 gap keeps operand", 32'(opb_q), 32'(sbv));
            end
            shift_en = 1'b1;
            ser_in = opd[i];
            if (poke && i == 2) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (i < W - 1) begin
                if (!(busy === 1'b1 && done === 1'b0))
                    chk("R7 pass continues", {busy, done}, 32'd2);
            end
        end
        shift_en = 1'b0;
        chk("R6 done after last step", 32'(done), 32'd1);
        chk("R6 busy low at done", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R6 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; start = 1'b0; shift_en = 1'b0; ser_in = 1'b0;
        m_a = '0; m_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 acc", 32'(acc_q), 32'd0);
        chk("R1 operand", 32'(opb_q), 32'd0);
        chk("R1 busy/done", {busy, done}, 32'd0);

        // R9: shift control while idle does nothing
        shift_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ser_in = i[0];
            @(negedge clk);
        end
        shift_en = 1'b0;
        chk("R9 idle acc", 32'(acc_q), 32'd0);
        chk("R9 idle operand", 32'(opb_q), 32'd0);
        chk("R9 idle busy", 32'(busy), 32'd0);

        run_pass(8'hB5, 0, 1'b0);          // load augend into operand register
        run_pass(8'h3C, 0, 1'b0);          // copy pass
        chk("R10 copy into cleared acc", 32'(acc_q), 32'hB5);
        run_pass(8'hFF, 3, 1'b0);          // B5+3C with gaps
        chk("R2 gapped sum", 32'(acc_q), 32'hF1);
        run_pass(8'h01, 0, 1'b1);          // F1+FF wraps, stray start ignored (R7)
        chk("R7 sum unaffected by stray start", 32'(acc_q), 32'hF0);
        run_pass(8'h80, 0, 1'b0);          // F0+01: carry from last pass must not leak
        chk("R3 carry cleared per pass", 32'(acc_q), 32'hF1);

        // R8: clear zeroes acc, keeps operand
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8 clr acc", 32'(acc_q), 32'd0);
        chk("R8 clr keeps operand", 32'(opb_q), 32'h80);
        m_a = '0;
        run_pass(8'h7E, 2, 1'b0);
        chk("R10 copy after clr", 32'(acc_q), 32'h80);

        for (int k = 0; k < 24; k++) begin
            run_pass(W'($urandom), k % 4, k[0]);
        end

        repeat (2) @(negedge clk);
        chk("R6 all results seen", 32'(sb.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule